// File: doc/BRIEF.md
# UART Receive Byte Queue with Threshold and Idle-Timeout Interrupts

This block sits between a serial deserializer that has already assembled received bytes and a processor that drains them. Bytes are stored in a small first-in first-out queue. The processor reads them one at a time with a read strobe. Read data appears on a registered output one cycle after the strobe.

Two interrupt lines tell the processor when to come and drain the queue. The fill-level interrupt is a level signal. It is high while the stored count is at or above a programmable trigger level. The idle-timeout interrupt catches the tail of a burst that never reaches the trigger level. It counts baud-tick pulses since the last byte arrival or processor read, and only while the queue holds data. Because the count is held at zero while the queue is empty, an idle line with an empty queue can never raise it. A handler clears it with a write-one acknowledge, or its cause ends when the handler drains the queue.

A byte that arrives while all entries are occupied is discarded. It sets a sticky overflow flag, which stays set until an acknowledge pulse clears it.

Top module: `uart_rxq`

## Requirements
- R1: After reset, level is 0, empty is 1, full is 0, overflow is 0, rd_data is 0, and both interrupt lines are low.
- R2: Bytes are returned in arrival order. rd_data holds the head byte from the clock edge that ends the cycle in which rd_stb was high. level follows the accepted writes and reads at that same edge. A write and a read in the same cycle leave level unchanged.
- R3: With DEPTH (16) entries stored, full is 1. A byte offered while full is discarded, even when a read occurs in the same cycle. The discard sets overflow, which stays 1 until ack_ovf is pulsed in a cycle with no discard.
- R4: rd_stb while the queue is empty leaves rd_data and level unchanged.
- R5: irq_thr is 1 exactly when thr_en is 1, trig_lvl is nonzero and level >= trig_lvl. It drops in the cycle in which reads bring level below trig_lvl. A trig_lvl of 0 never raises it.
- R6: With trig_lvl = 1, every byte written into an empty queue raises irq_thr.
- R7: With tmo_en = 1 and the queue non-empty, irq_tmo rises at the edge that ends the cycle of the tmo_val-th baud_tick pulse counted since the last byte_vld or rd_stb. Each byte_vld or rd_stb restarts the count from zero. A tmo_val of 0 never fires.
- R8: irq_tmo is never 1 while empty is 1, however many baud ticks pass.
- R9: The timeout fires once per quiet period. After it has been acknowledged, further ticks do not raise it again until a byte_vld or rd_stb starts a new full period.
- R10: ack_tmo clears irq_tmo at the next edge. Reading the queue until it is empty also drops irq_tmo.
- R11: With tmo_en = 0, irq_tmo stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | 1 | One-cycle strobe: a received byte is on byte_in |
| byte_in | input | DW (8) | Received byte |
| baud_tick | input | 1 | One-cycle pulse per baud period, used as the timeout time base |
| rd_stb | input | 1 | Processor read strobe, pops the head byte |
| trig_lvl | input | CW (5) | Fill-level interrupt trigger, 0 disables it |
| tmo_val | input | TMO_W (8) | Timeout length in baud ticks, 0 disables it |
| thr_en | input | 1 | Enable for the fill-level interrupt |
| tmo_en | input | 1 | Enable for the idle-timeout interrupt |
| ack_tmo | input | 1 | Write-one pulse that clears a pending timeout |
| ack_ovf | input | 1 | Write-one pulse that clears the overflow flag |
| rd_data | output | DW (8) | Last byte popped |
| level | output | CW (5) | Number of stored bytes |
| empty | output | 1 | level is 0 |
| full | output | 1 | level equals DEPTH |
| overflow | output | 1 | Sticky: a byte was discarded |
| irq_thr | output | 1 | Fill-level interrupt |
| irq_tmo | output | 1 | Idle-timeout interrupt |

## Verification
Two collisions are provoked. The first is a byte arrival and a processor read in the same cycle. It is driven with the queue partly filled, where level must stay put and the popped byte must be the older head. It is also driven with the queue full, where the arriving byte must be discarded, overflow must set and level must fall to 15. The second is a byte arrival landing two ticks into a quiet period. The bench judges it by checking that the interrupt does not fire at the old deadline and fires only after a fresh full count of ticks.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   // width of an occupancy count able to hold 0..depth
   function automatic int rxq_cnt_w(input int depth);
      return $clog2(depth + 1);
   endfunction

   // a depth that is a power of two lets pointers wrap on their own
   function automatic bit rxq_is_pow2(input int depth);
      return (depth > 0) && ((depth & (depth - 1)) == 0);
   endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store
   import rxq_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int DW    = 8,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = rxq_cnt_w(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_req,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_req,
   output logic [DW-1:0] rd_data,
   output logic [CW-1:0] level,
   output logic          empty,
   output logic          full,
   output logic          drop
);
   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wptr, rptr, wptr_nx, rptr_nx;
   logic          wr_do, rd_do;

   assign full  = (level == CW'(DEPTH));
   assign empty = (level == '0);
   assign wr_do = wr_req && !full;
   assign rd_do = rd_req && !empty;
   assign drop  = wr_req && full;

   generate
      if (rxq_is_pow2(DEPTH)) begin : g_wrap_free
         assign wptr_nx = wptr + 1'b1;
         assign rptr_nx = rptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wptr_nx = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
         assign rptr_nx = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (wr_do) mem[wptr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr    <= '0;
         rptr    <= '0;
         level   <= '0;
         rd_data <= '0;
      end else begin
         if (wr_do) wptr <= wptr_nx;
         if (rd_do) begin
            rptr    <= rptr_nx;
            rd_data <= mem[rptr];
         end
         unique case ({wr_do, rd_do})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          restart,
   input  logic          hold,
   input  logic [TW-1:0] limit,
   output logic          fire
);
   logic [TW-1:0] cnt;
   logic          armed;
   logic [TW:0]   cnt_inc;
   logic          step;

   assign cnt_inc = {1'b0, cnt} + 1'b1;
   assign step    = tick && armed && !hold && !restart;
   assign fire    = step && (cnt_inc == {1'b0, limit});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt   <= '0;
         armed <= 1'b1;
      end else if (hold || restart) begin
         cnt   <= '0;
         armed <= 1'b1;
      end else if (step) begin
         cnt <= cnt_inc[TW-1:0];
         if (fire) armed <= 1'b0;
      end
   end
endmodule

// File: rtl/rxq_irq.sv
module rxq_irq #(
   parameter int CW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] level,
   input  logic          empty,
   input  logic [CW-1:0] trig_lvl,
   input  logic          thr_en,
   input  logic          tmo_en,
   input  logic          fire,
   input  logic          ack_tmo,
   input  logic          drop,
   input  logic          ack_ovf,
   output logic          irq_thr,
   output logic          irq_tmo,
   output logic          overflow
);
   logic pend;

   assign irq_thr = thr_en && (trig_lvl != '0) && (level >= trig_lvl);
   assign irq_tmo = pend && tmo_en && !empty;

   always_ff @(posedge clk) begin
      if (!rst_n)                pend <= 1'b0;
      else if (empty || !tmo_en) pend <= 1'b0;
      else if (fire)             pend <= 1'b1;
      else if (ack_tmo)          pend <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       overflow <= 1'b0;
      else if (drop)    overflow <= 1'b1;
      else if (ack_ovf) overflow <= 1'b0;
   end
endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
   import rxq_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int DW    = 8,
   parameter int TMO_W = 8,
   localparam int CW   = rxq_cnt_w(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             byte_vld,
   input  logic [DW-1:0]    byte_in,
   input  logic             baud_tick,
   input  logic             rd_stb,
   input  logic [CW-1:0]    trig_lvl,
   input  logic [TMO_W-1:0] tmo_val,
   input  logic             thr_en,
   input  logic             tmo_en,
   input  logic             ack_tmo,
   input  logic             ack_ovf,
   output logic [DW-1:0]    rd_data,
   output logic [CW-1:0]    level,
   output logic             empty,
   output logic             full,
   output logic             overflow,
   output logic             irq_thr,
   output logic             irq_tmo
);
   generate
      if (DEPTH < 2)  begin : g_bad_depth $error("uart_rxq: DEPTH must be at least 2"); end
      if (DW < 1)     begin : g_bad_dw    $error("uart_rxq: DW must be positive"); end
      if (TMO_W < 1)  begin : g_bad_tw    $error("uart_rxq: TMO_W must be positive"); end
   endgenerate

   logic drop, fire;

   rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_req  (byte_vld),
      .wr_data (byte_in),
      .rd_req  (rd_stb),
      .rd_data (rd_data),
      .level   (level),
      .empty   (empty),
      .full    (full),
      .drop    (drop)
   );

   rxq_idle_timer #(.TW(TMO_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (baud_tick),
      .restart (byte_vld || rd_stb),
      .hold    (empty),
      .limit   (tmo_val),
      .fire    (fire)
   );

   rxq_irq #(.CW(CW)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .level    (level),
      .empty    (empty),
      .trig_lvl (trig_lvl),
      .thr_en   (thr_en),
      .tmo_en   (tmo_en),
      .fire     (fire),
      .ack_tmo  (ack_tmo),
      .drop     (drop),
      .ack_ovf  (ack_ovf),
      .irq_thr  (irq_thr),
      .irq_tmo  (irq_tmo),
      .overflow (overflow)
   );
endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
   parameter int DEPTH = 16,
   parameter int DW    = 8,
   parameter int TMO_W = 8,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             byte_vld,
   input logic [DW-1:0]    byte_in,
   input logic             baud_tick,
   input logic             rd_stb,
   input logic [CW-1:0]    trig_lvl,
   input logic [TMO_W-1:0] tmo_val,
   input logic             thr_en,
   input logic             tmo_en,
   input logic             ack_tmo,
   input logic             ack_ovf,
   input logic [DW-1:0]    rd_data,
   input logic [CW-1:0]    level,
   input logic             empty,
   input logic             full,
   input logic             overflow,
   input logic             irq_thr,
   input logic             irq_tmo
);
   p_level_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      level <= CW'(DEPTH));
   p_drop_sets_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
      full && byte_vld |=> overflow && full || overflow && rd_stb);
   p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      overflow && !ack_ovf |=> overflow);
   p_empty_read_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb && !byte_vld && empty |=> $stable(rd_data) && empty);
   p_thr_below_r5: assert property (@(posedge clk) disable iff (!rst_n)
      level < trig_lvl |-> !irq_thr);
   p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld || rd_stb) && !irq_tmo |=> !irq_tmo);
   p_no_tmo_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> !irq_tmo);
   p_ack_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_tmo && ack_tmo && !baud_tick |=> !irq_tmo);
   p_tmo_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !tmo_en |-> !irq_tmo);
endmodule

bind uart_rxq rxq_chk #(.DEPTH(DEPTH), .DW(DW), .TMO_W(TMO_W)) u_chk (.*);

// File: tb/uart_rxq_test.sv
module uart_rxq_test;
   localparam int DEPTH = 16;
   localparam int DW    = 8;
   localparam int TW    = 8;
   localparam int CW    = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          byte_vld = 1'b0;
   logic [DW-1:0] byte_in = '0;
   logic          baud_tick = 1'b0;
   logic          rd_stb = 1'b0;
   logic [CW-1:0] trig_lvl = '0;
   logic [TW-1:0] tmo_val = '0;
   logic          thr_en = 1'b0, tmo_en = 1'b0, ack_tmo = 1'b0, ack_ovf = 1'b0;
   logic [DW-1:0] rd_data;
   logic [CW-1:0] level;
   logic          empty, full, overflow, irq_thr, irq_tmo;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   uart_rxq #(.DEPTH(DEPTH), .DW(DW), .TMO_W(TW)) uut (
      .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in),
      .baud_tick(baud_tick), .rd_stb(rd_stb), .trig_lvl(trig_lvl),
      .tmo_val(tmo_val), .thr_en(thr_en), .tmo_en(tmo_en),
      .ack_tmo(ack_tmo), .ack_ovf(ack_ovf), .rd_data(rd_data),
      .level(level), .empty(empty), .full(full), .overflow(overflow),
      .irq_thr(irq_thr), .irq_tmo(irq_tmo)
   );

   // vector: {wr, data, rd, expected level, expected rd_data}
   localparam int NV = 12;
   localparam logic [22:0] VEC [NV] = '{
      {1'b1, 8'hA1, 1'b0, 5'd1, 8'h00},
      {1'b1, 8'hB2, 1'b0, 5'd2, 8'h00},
      {1'b1, 8'hC3, 1'b1, 5'd2, 8'hA1},
      {1'b0, 8'h00, 1'b1, 5'd1, 8'hB2},
      {1'b0, 8'h00, 1'b1, 5'd0, 8'hC3},
      {1'b0, 8'h00, 1'b1, 5'd0, 8'hC3},
      {1'b1, 8'h5A, 1'b0, 5'd1, 8'h00},
      {1'b1, 8'h6B, 1'b1, 5'd1, 8'h5A},
      {1'b1, 8'h7C, 1'b0, 5'd2, 8'h00},
      {1'b1, 8'h8D, 1'b0, 5'd3, 8'h00},
      {1'b1, 8'h9E, 1'b0, 5'd4, 8'h00},
      {1'b0, 8'h00, 1'b1, 5'd3, 8'h6B}
   };

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // drive for one cycle, return after the edge, sampling at negedge
   task automatic cyc(input bit wr, input logic [7:0] d, input bit rd, input bit tk);
      byte_vld = wr; byte_in = d; rd_stb = rd; baud_tick = tk;
      @(negedge clk);
      byte_vld = 1'b0; rd_stb = 1'b0; baud_tick = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         cyc(1'b0, 8'h00, 1'b0, 1'b1);
         @(negedge clk);
      end
   endtask

   task automatic drain();
      while (!empty) cyc(1'b0, 8'h00, 1'b1, 1'b0);
   endtask

   initial begin
      #(8 * 100000);
      if (!done) begin
         chk(1'b0, "watchdog", 0, 1);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(level == 0 && empty && !full, "R1 level/empty", int'(level), 0);
      chk(!overflow && rd_data == 0, "R1 ovf/rd_data", int'(rd_data), 0);
      chk(!irq_thr && !irq_tmo, "R1 irqs", int'(irq_thr) + int'(irq_tmo), 0);

      // table walk: R2 order and level, R4 empty read, R5 threshold at 4
      trig_lvl = 5'd4; thr_en = 1'b1;
      for (int v = 0; v < NV; v++) begin
         logic [22:0] e;
         e = VEC[v];
         cyc(e[22], e[21:14], e[13], 1'b0);
         chk(level == e[12:8], "R2 level", int'(level), int'(e[12:8]));
         if (e[13]) chk(rd_data == e[7:0], "R2/R4 rd_data", int'(rd_data), int'(e[7:0]));
         chk(irq_thr == (e[12:8] >= 5'd4), "R5 irq_thr", int'(irq_thr), int'(e[12:8] >= 5'd4));
      end
      // level now 3, trig 4: add one, then disable thr_en
      cyc(1'b1, 8'hAF, 1'b0, 1'b0);
      chk(irq_thr, "R5 at trigger", int'(irq_thr), 1);
      thr_en = 1'b0; #1;
      chk(!irq_thr, "R5 disabled", int'(irq_thr), 0);
      thr_en = 1'b1; trig_lvl = 5'd0; #1;
      chk(!irq_thr, "R5 trig zero", int'(irq_thr), 0);
      drain();

      // R6: trig 1 raises per byte
      trig_lvl = 5'd1;
      for (int k = 0; k < 3; k++) begin
         cyc(1'b1, 8'(8'h30 + k), 1'b0, 1'b0);
         chk(irq_thr, "R6 byte irq", int'(irq_thr), 1);
         cyc(1'b0, 8'h00, 1'b1, 1'b0);
         chk(!irq_thr && rd_data == 8'(8'h30 + k), "R6 drop after read", int'(rd_data), 8'h30 + k);
      end
      thr_en = 1'b0;

      // R3: fill, overflow, collision of arrival and read when full
      for (int k = 0; k < DEPTH; k++) cyc(1'b1, 8'(8'h10 + k), 1'b0, 1'b0);
      chk(full && level == 16 && !overflow, "R3 full", int'(level), 16);
      cyc(1'b1, 8'hEE, 1'b0, 1'b0);
      chk(overflow && level == 16, "R3 drop sets ovf", int'(overflow), 1);
      cyc(1'b1, 8'hEF, 1'b1, 1'b0);
      chk(level == 15 && rd_data == 8'h10, "R3 full collision", int'(level), 15);
      for (int k = 1; k < DEPTH; k++) begin
         cyc(1'b0, 8'h00, 1'b1, 1'b0);
         chk(rd_data == 8'(8'h10 + k), "R2 order", int'(rd_data), 8'h10 + k);
      end
      chk(empty && overflow, "R3 ovf sticky", int'(overflow), 1);
      ack_ovf = 1'b1; @(negedge clk); ack_ovf = 1'b0;
      chk(!overflow, "R3 ack_ovf", int'(overflow), 0);

      // R7: timeout after tmo_val ticks
      tmo_val = 8'd3; tmo_en = 1'b1;
      cyc(1'b1, 8'h41, 1'b0, 1'b0);
      ticks(2);
      chk(!irq_tmo, "R7 early", int'(irq_tmo), 0);
      ticks(1);
      chk(irq_tmo, "R7 fire", int'(irq_tmo), 1);
      // R10 ack
      ack_tmo = 1'b1; @(negedge clk); ack_tmo = 1'b0;
      chk(!irq_tmo, "R10 ack clears", int'(irq_tmo), 0);
      // R9 no refire
      ticks(6);
      chk(!irq_tmo, "R9 one shot", int'(irq_tmo), 0);
      // R7 restart by arrival mid-count
      cyc(1'b1, 8'h42, 1'b0, 1'b0);
      ticks(2);
      cyc(1'b1, 8'h43, 1'b0, 1'b0);
      ticks(2);
      chk(!irq_tmo, "R7 restart", int'(irq_tmo), 0);
      ticks(1);
      chk(irq_tmo, "R7 fire after restart", int'(irq_tmo), 1);
      // R10 drain to empty
      drain();
      chk(!irq_tmo, "R10 drained", int'(irq_tmo), 0);
      // R8 empty idle
      ticks(10);
      chk(!irq_tmo, "R8 empty idle", int'(irq_tmo), 0);
      // R11 disabled
      tmo_en = 1'b0;
      cyc(1'b1, 8'h44, 1'b0, 1'b0);
      ticks(5);
      chk(!irq_tmo, "R11 disabled", int'(irq_tmo), 0);
      drain();
      // R7 zero limit never fires
      tmo_en = 1'b1; tmo_val = 8'd0;
      cyc(1'b1, 8'h45, 1'b0, 1'b0);
      ticks(20);
      chk(!irq_tmo, "R7 zero limit", int'(irq_tmo), 0);
      drain();

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule